// File: doc/BRIEF.md
# Row overhead interval sequencer

This block times the overhead interval that precedes the readout of each row in an image sensor. It runs on a master clock and counts in sensor clocks, one sensor clock being four master clocks. A row-start request, accepted while the block is idle and enabled, opens an interval. The interval has one of two lengths: a fixed long length, or a programmable length of N+2 sensor clocks, where N comes from a 5-bit timer field. A column precharge pulse opens every interval. Its width is 1, 2 or 3 sensor clocks, and the width never alters the total interval length.

The control and timer register values arrive as plain inputs. The block copies the fields it uses when an interval starts, so a register write during an interval only affects the next one. When the power-down bit is set, or the active-low sequencer reset bit is cleared, the block is halted. It aborts any running interval, clears its counters and refuses new requests. The dual slope enable bit passes straight through to an output for the analog side.

Top module: `rowoh_seq`

## Requirements
- R1: Every interval lasts a whole number of sensor clocks, each four master clocks long, counted from the first master clock in which `ovh_busy` is high.
- R2: With `ctrl_bits[2]` = 1 (reduced mode), `ovh_busy` stays high for (N+2)×4 master clocks, where N = `timer_bits[4:0]`.
- R3: With `ctrl_bits[2]` = 0 (long mode), `ovh_busy` stays high for 140 master clocks whatever the timer value.
- R4: Bits 7:5 of `timer_bits` have no effect on the interval length.
- R5: `col_precharge` is high from the first interval cycle for 4, 8, 12 or 12 master clocks for width code `ctrl_bits[5:4]` = 00, 01, 10 or 11. The pulse is cut short if the interval ends first, and it is never high outside an interval.
- R6: The precharge width code does not change the total interval length.
- R7: `ovh_done` is high for exactly one master clock, in the last cycle in which `ovh_busy` is high.
- R8: While `ctrl_bits[0]` = 1 (power down) or `ctrl_bits[1]` = 0 (sequencer reset), no interval starts. If an interval is running, `ovh_busy` and `col_precharge` are low from the next cycle.
- R9: Mode, timer and width are sampled when an interval starts. Changing them during the interval does not change its length or its precharge width.
- R10: A `row_start` request while `ovh_busy` is high is ignored and does not queue a new interval.
- R11: `dual_slope_en` always equals `ctrl_bits[3]`.
- R12: An accepted `row_start` makes `ovh_busy` and `col_precharge` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_start | input | 1 | Request to open a row overhead interval |
| ctrl_bits | input | 6 | Control fields: 0 power down, 1 run (active-low reset), 2 reduced mode, 3 dual slope, 5:4 precharge width code |
| timer_bits | input | 8 | Interval timer register, bits 4:0 used |
| col_precharge | output | 1 | Column precharge pulse |
| ovh_busy | output | 1 | Interval active |
| ovh_done | output | 1 | One-cycle strobe on the last interval cycle |
| dual_slope_en | output | 1 | Pass-through of the dual slope enable bit |

## Verification
The hardest cases to reach from the ports are writes to registers and requests that arrive in the middle of an interval. They must not disturb the snapshot or the counter. The directed task that opens an interval therefore rewrites the timer to zero, flips the mode and width, and raises `row_start` again five cycles into the interval. It then confirms that the length and pulse width match the values in force at the start, and that no second interval follows. A halt in the middle of an interval is reached the same way: power down is set partway through, and the bench checks that busy and precharge both collapse one cycle later.

// File: rtl/rowoh_pkg.sv
package rowoh_pkg;
   // control field positions (decoded by the surrounding register block)
   localparam int unsigned CTL_PWRDN   = 0;
   localparam int unsigned CTL_RUN     = 1;
   localparam int unsigned CTL_REDUCED = 2;
   localparam int unsigned CTL_DSLOPE  = 3;
   localparam int unsigned CTL_PREW_LO = 4;
   localparam int unsigned CTL_W       = 6;
   localparam int unsigned PREW_CODE_W = 2;

   typedef struct packed {
      logic [PREW_CODE_W-1:0] prew_code;
      logic                   dslope;
      logic                   reduced;
      logic                   run;
      logic                   pwrdn;
   } ctl_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rowoh_tick.sv
module rowoh_tick #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad
         $error("rowoh_tick: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_count
         localparam int unsigned PH_W = $clog2(DIV);
         localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
         logic [PH_W-1:0] phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  phase_q <= '0;
            else if (clr)                phase_q <= '0;
            else if (phase_q == PH_LAST) phase_q <= '0;
            else                         phase_q <= phase_q + 1'b1;
         end
         assign tick = (phase_q == PH_LAST);
      end
   endgenerate
endmodule

// File: rtl/rowoh_snap.sv
module rowoh_snap #(
   parameter int unsigned TIMER_W  = 5,
   parameter int unsigned LONG_LEN = 35,
   parameter int unsigned PRE_MAX  = 3,
   parameter int unsigned CODE_W   = 2,
   parameter int unsigned LEN_W    = 6,
   parameter int unsigned PRE_W    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               reduced,
   input  logic [TIMER_W-1:0] timer,
   input  logic [CODE_W-1:0]  code,
   output logic [LEN_W-1:0]   len_q,
   output logic [PRE_W-1:0]   prew_q
);
   localparam logic [LEN_W-1:0] LONG_V  = LEN_W'(LONG_LEN);
   localparam logic [PRE_W-1:0] PMAX_V  = PRE_W'(PRE_MAX);
   localparam int unsigned      RST_N   = 7;

   logic [LEN_W-1:0] len_d;
   logic [PRE_W-1:0] prew_d;
   logic [PRE_W:0]   code_p1;

   always_comb begin
      len_d   = reduced ? (LEN_W'(timer) + LEN_W'(2)) : LONG_V;
      code_p1 = (PRE_W + 1)'(code) + 1'b1;
      prew_d  = (code_p1 > (PRE_W + 1)'(PRE_MAX)) ? PMAX_V : PRE_W'(code_p1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= LEN_W'(RST_N + 2);
         prew_q <= PRE_W'(1);
      end else if (load) begin
         len_q  <= len_d;
         prew_q <= prew_d;
      end
   end
endmodule

// File: rtl/rowoh_span.sv
module rowoh_span #(
   parameter int unsigned LEN_W = 6,
   parameter int unsigned PRE_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt,
   input  logic             start,
   input  logic             tick,
   input  logic [LEN_W-1:0] len,
   input  logic [PRE_W-1:0] prew,
   output logic             busy,
   output logic             precharge,
   output logic             done
);
   logic             busy_q;
   logic [LEN_W-1:0] scnt_q;
   logic             last;

   assign last = busy_q & tick & (scnt_q == LEN_W'(len - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         scnt_q <= '0;
      end else if (halt) begin
         busy_q <= 1'b0;
         scnt_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         scnt_q <= '0;
      end else if (busy_q && tick) begin
         if (last) begin
            busy_q <= 1'b0;
            scnt_q <= '0;
         end else begin
            scnt_q <= scnt_q + 1'b1;
         end
      end
   end

   assign busy      = busy_q;
   assign precharge = busy_q & (scnt_q < LEN_W'(prew));
   assign done      = last;

   AST_COUNT_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (scnt_q < len)); // R2
   AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (scnt_q == '0)); // R1
   AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !busy_q); // R7
endmodule

// File: rtl/rowoh_seq.sv
module rowoh_seq #(
   parameter int unsigned DIV      = 4,
   parameter int unsigned TIMER_W  = 5,
   parameter int unsigned LONG_LEN = 35,
   parameter int unsigned PRE_MAX  = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       row_start,
   input  logic [5:0] ctrl_bits,
   input  logic [7:0] timer_bits,
   output logic       col_precharge,
   output logic       ovh_busy,
   output logic       ovh_done,
   output logic       dual_slope_en
);
   import rowoh_pkg::*;

   localparam int unsigned MAX_LEN = max2(LONG_LEN, (1 << TIMER_W) + 1);
   localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);
   localparam int unsigned PRE_W   = $clog2(PRE_MAX + 1);

   generate
      if (TIMER_W < 1 || TIMER_W > 8) begin : g_bad_timer
         $error("rowoh_seq: TIMER_W must lie in 1..8");
      end
      if (LONG_LEN < 2) begin : g_bad_long
         $error("rowoh_seq: LONG_LEN must be at least 2");
      end
      if (PRE_MAX < 1 || PRE_MAX > (1 << PREW_CODE_W)) begin : g_bad_pre
         $error("rowoh_seq: PRE_MAX out of range for the width code");
      end
   endgenerate

   ctl_t ctl;
   logic enabled, halt, start, tick, div_clr;
   logic [LEN_W-1:0] len_q;
   logic [PRE_W-1:0] prew_q;

   assign ctl           = ctl_t'(ctrl_bits);
   assign enabled       = ~ctl.pwrdn & ctl.run;
   assign halt          = ~enabled;
   assign start         = enabled & ~ovh_busy & row_start;
   assign div_clr       = halt | ~ovh_busy;
   assign dual_slope_en = ctl.dslope;

   rowoh_tick #(.DIV(DIV)) i_tick (
      .clk(clk), .rst_n(rst_n), .clr(div_clr), .tick(tick)
   );

   rowoh_snap #(
      .TIMER_W(TIMER_W), .LONG_LEN(LONG_LEN), .PRE_MAX(PRE_MAX),
      .CODE_W(PREW_CODE_W), .LEN_W(LEN_W), .PRE_W(PRE_W)
   ) i_snap (
      .clk(clk), .rst_n(rst_n), .load(start), .reduced(ctl.reduced),
      .timer(timer_bits[TIMER_W-1:0]), .code(ctl.prew_code),
      .len_q(len_q), .prew_q(prew_q)
   );

   rowoh_span #(.LEN_W(LEN_W), .PRE_W(PRE_W)) i_span (
      .clk(clk), .rst_n(rst_n), .halt(halt), .start(start), .tick(tick),
      .len(len_q), .prew(prew_q),
      .busy(ovh_busy), .precharge(col_precharge), .done(ovh_done)
   );

   AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (enabled && !ovh_busy && row_start) |=> (ovh_busy && col_precharge)); // R12
   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled |=> (!ovh_busy && !col_precharge)); // R8
   AST_PRE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      col_precharge |-> ovh_busy); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ovh_done |=> !ovh_done); // R7
   AST_DONE_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      ovh_done |-> ovh_busy); // R7
endmodule

// File: tb/test_rowoh_seq.sv
module test_rowoh_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       row_start = 1'b0;
   logic [5:0] ctrl_bits = 6'b000110;
   logic [7:0] timer_bits = 8'h07;
   logic       col_precharge, ovh_busy, ovh_done, dual_slope_en;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk; // 50 MHz

   rowoh_seq i_rowoh_seq (
      .clk(clk), .rst_n(rst_n), .row_start(row_start),
      .ctrl_bits(ctrl_bits), .timer_bits(timer_bits),
      .col_precharge(col_precharge), .ovh_busy(ovh_busy),
      .ovh_done(ovh_done), .dual_slope_en(dual_slope_en)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // opens one interval and measures it; poke disturbs inputs mid-interval
   task automatic run_iv(input logic [5:0] c, input logic [7:0] t, input bit poke,
                         output int len, output int pre, output int dn, output int dn_at);
      @(negedge clk);
      ctrl_bits = c; timer_bits = t; row_start = 1'b1;
      @(negedge clk);
      row_start = 1'b0;
      len = 0; pre = 0; dn = 0; dn_at = -1;
      while (ovh_busy && len < 1000) begin
         len++;
         if (col_precharge) pre++;
         if (ovh_done) begin dn++; dn_at = len; end
         if (poke && len == 5) begin
            timer_bits = 8'h00; ctrl_bits[5:4] = 2'b00;
            ctrl_bits[2] = ~ctrl_bits[2]; row_start = 1'b1;
         end else begin
            row_start = 1'b0;
         end
         @(negedge clk);
      end
      row_start = 1'b0;
   endtask

   task automatic t_interval(input string req, input logic [5:0] c, input logic [7:0] t,
                             input int exp_len, input int exp_pre);
      int len, pre, dn, dn_at;
      run_iv(c, t, 1'b0, len, pre, dn, dn_at);
      chk({req, " length"}, len, exp_len);
      chk({req, " precharge"}, pre, exp_pre);
      chk("R7 done count", dn, 1);
      chk("R7 done on last cycle", dn_at, len);
      chk("R1 whole sensor clocks", len % 4, 0);
   endtask

   task automatic t_reset;
      chk("R12 reset busy", int'(ovh_busy), 0);
      chk("R5 reset precharge", int'(col_precharge), 0);
      chk("R7 reset done", int'(ovh_done), 0);
   endtask

   task automatic t_mid_changes;
      int len, pre, dn, dn_at;
      run_iv(6'b100110, 8'h07, 1'b1, len, pre, dn, dn_at);
      chk("R9 length held", len, 36);
      chk("R9 precharge held", pre, 12);
      chk("R10 single done", dn, 1);
      @(negedge clk);
      chk("R10 no queued interval", int'(ovh_busy), 0);
      @(negedge clk);
      chk("R10 still idle", int'(ovh_busy), 0);
   endtask

   task automatic t_halt(input logic [5:0] c, input string req);
      @(negedge clk);
      ctrl_bits = c; row_start = 1'b1;
      @(negedge clk);
      row_start = 1'b0;
      chk({req, " no start busy"}, int'(ovh_busy), 0);
      chk({req, " no start precharge"}, int'(col_precharge), 0);
      repeat (3) @(negedge clk);
      chk({req, " still idle"}, int'(ovh_busy), 0);
   endtask

   task automatic t_abort;
      @(negedge clk);
      ctrl_bits = 6'b000110; timer_bits = 8'h07; row_start = 1'b1;
      @(negedge clk);
      row_start = 1'b0;
      chk("R12 busy after start", int'(ovh_busy), 1);
      chk("R12 precharge after start", int'(col_precharge), 1);
      repeat (2) @(negedge clk);
      ctrl_bits[0] = 1'b1;
      @(negedge clk);
      chk("R8 abort busy", int'(ovh_busy), 0);
      chk("R8 abort precharge", int'(col_precharge), 0);
      ctrl_bits[0] = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8 stays idle after release", int'(ovh_busy), 0);
   endtask

   task automatic t_dslope;
      @(negedge clk);
      ctrl_bits = 6'b001110;
      #1 chk("R11 dual slope high", int'(dual_slope_en), 1);
      ctrl_bits = 6'b000110;
      #1 chk("R11 dual slope low", int'(dual_slope_en), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_interval("R2 N=7", 6'b000110, 8'h07, 36, 4);
      t_interval("R2 N=0", 6'b000110, 8'h00, 8, 4);
      t_interval("R2 N=31", 6'b000110, 8'h1F, 132, 4);
      t_interval("R4 upper bits", 6'b000110, 8'hE3, 20, 4);
      t_interval("R3 long timer 5", 6'b000010, 8'h05, 140, 4);
      t_interval("R3 long timer 31", 6'b010010, 8'h1F, 140, 8);
      t_interval("R5 R6 code 01", 6'b010110, 8'h07, 36, 8);
      t_interval("R5 R6 code 10", 6'b100110, 8'h07, 36, 12);
      t_interval("R5 R6 code 11", 6'b110110, 8'h07, 36, 12);
      t_interval("R5 cut by end", 6'b100110, 8'h00, 8, 8);
      t_mid_changes();
      t_halt(6'b000111, "R8 power down");
      t_halt(6'b000100, "R8 seq reset");
      t_abort();
      t_dslope();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule